// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block decides which of eight DRAM rows serves a host physical address. Software programs one 8-bit cumulative end value per row, counted in 8 MB units, so the end value of row i is the total size of rows 0 through i. The block compares the upper address bits against each row's window (previous end value up to its own end value) and reports the owning row as a one-hot vector and as a binary index, together with a DRAM-hit flag.

Two fixed windows can be cut out of DRAM by a 2-bit hole code: a 128 KB window just below 640 KB and a 1 MB window just below 16 MB. An address inside an enabled window never reaches DRAM and raises a hole flag instead. Addresses that fall past the last row's end value hit nothing. All outputs are registered, one clock after the inputs are sampled.

Top module: `drb_decoder`

## Requirements
- R1: While rst_n is low, row_sel_o, row_idx_o, dram_hit_o and hole_o are all zero.
- R2: Every output reflects the inputs sampled at the previous rising clock edge; a change of the inputs between edges leaves the outputs unchanged until the next edge.
- R3: With E[i] the 8-bit end value in bounds_i[8*i+7:8*i] and E[-1] = 0, row i owns addresses with E[i-1]*8 MB <= address < E[i]*8 MB (the 8 MB unit is address bit 23 and up); for an owned address row_sel_o has exactly bit i set, row_idx_o equals i and dram_hit_o is 1.
- R4: A row whose end value equals the previous row's end value owns no address and is never selected.
- R5: An address at or above E[7]*8 MB (monotonic end values) yields row_sel_o = 0, row_idx_o = 0, dram_hit_o = 0 and hole_o = 0.
- R6: With hole_en_i = 2'b01, addresses 0x80000 to 0x9FFFF give hole_o = 1, dram_hit_o = 0, row_sel_o = 0 and row_idx_o = 0, whatever the end values are.
- R7: With hole_en_i = 2'b10, addresses 0xF00000 to 0xFFFFFF give hole_o = 1, dram_hit_o = 0, row_sel_o = 0 and row_idx_o = 0, whatever the end values are.
- R8: hole_en_i = 2'b00 and the reserved 2'b11 both cut no window: hole_o stays 0 and both windows decode as ordinary DRAM.
- R9: When end values are not non-decreasing, the lowest-numbered row whose window holds the address is selected; with ORDER_CHECK = 1 such a configuration is reported as an error by the checker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (32) | Host physical address |
| bounds_i | input | NUM_ROWS*BND_W (64) | Cumulative row end values, row i in bits [8*i+7:8*i], 8 MB units |
| hole_en_i | input | 2 | Hole code: 00 none, 01 low window, 10 high window, 11 reserved (none) |
| row_sel_o | output | NUM_ROWS (8) | One-hot owning row |
| row_idx_o | output | IDX_W (3) | Binary index of the owning row, 0 when none |
| dram_hit_o | output | 1 | Address is served by a populated row |
| hole_o | output | 1 | Address lies in an enabled hole window |

## Verification
The order assertion assumes that software programs non-decreasing end values whenever ORDER_CHECK is set, so the main instance only ever sees monotonic configurations; misordered end values are applied only to a second instance built with ORDER_CHECK = 0. The hole-window assertions take the address and hole code of the previous cycle as the cause of hole_o, which holds because the bench changes inputs only at the falling edge. The sweeps cover every hole code against several boundary sets, including empty leading rows, repeated end values, an all-zero set and a set reaching the top code 255.

// File: rtl/drb_pkg.sv
package drb_pkg;

  typedef enum logic [1:0] {
    HOLE_NONE = 2'b00,
    HOLE_LOW  = 2'b01,
    HOLE_HIGH = 2'b10,
    HOLE_RSVD = 2'b11
  } hole_code_e;

  localparam logic [31:0] LOW_HOLE_BASE  = 32'h0008_0000;
  localparam logic [31:0] LOW_HOLE_END   = 32'h000A_0000;
  localparam logic [31:0] HIGH_HOLE_BASE = 32'h00F0_0000;
  localparam logic [31:0] HIGH_HOLE_END  = 32'h0100_0000;

  // Address lies in the window selected by the hole code (end exclusive).
  function automatic logic hole_hit(input logic [31:0] a, input hole_code_e c);
    case (c)
      HOLE_LOW:  return (a >= LOW_HOLE_BASE)  && (a < LOW_HOLE_END);
      HOLE_HIGH: return (a >= HIGH_HOLE_BASE) && (a < HIGH_HOLE_END);
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/drb_row_cmp.sv
module drb_row_cmp #(
  parameter int NUM_ROWS = 8,
  parameter int BND_W    = 8,
  parameter int UNIT_W   = 9
) (
  input  logic [UNIT_W-1:0]         unit_i,
  input  logic [NUM_ROWS*BND_W-1:0] bounds_i,
  output logic [NUM_ROWS-1:0]       match_o,
  output logic                      order_err_o
);
  localparam int CW = UNIT_W + BND_W;

  logic [CW-1:0]       unit_x;
  logic [NUM_ROWS-1:0] dec_w;

  assign unit_x = CW'(unit_i);

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    logic [CW-1:0] lo_w, hi_w;
    assign hi_w = CW'(bounds_i[i*BND_W +: BND_W]);
    if (i == 0) begin : g_first
      assign lo_w     = '0;
      assign dec_w[i] = 1'b0;
    end else begin : g_rest
      assign lo_w     = CW'(bounds_i[(i-1)*BND_W +: BND_W]);
      assign dec_w[i] = hi_w < lo_w;
    end
    assign match_o[i] = (unit_x >= lo_w) && (unit_x < hi_w);
  end

  assign order_err_o = |dec_w;
endmodule

// File: rtl/drb_prio_pick.sv
module drb_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     match_i,
  output logic [N-1:0]     onehot_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    onehot_o = '0;
    idx_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        onehot_o    = '0;
        onehot_o[i] = 1'b1;
        idx_o       = IDX_W'(i);
      end
    end
  end

  assign any_o = |match_i;
endmodule

// File: rtl/drb_hole_chk.sv
module drb_hole_chk #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        hole_en_i,
  output logic              in_hole_o
);
  logic [31:0] a32;
  assign a32       = 32'(addr_i);
  assign in_hole_o = drb_pkg::hole_hit(a32, drb_pkg::hole_code_e'(hole_en_i));
endmodule

// File: rtl/drb_decoder.sv
module drb_decoder #(
  parameter int ADDR_W      = 32,
  parameter int NUM_ROWS    = 8,
  parameter int BND_W       = 8,
  parameter int UNIT_SHIFT  = 23,
  parameter bit ORDER_CHECK = 1'b1,
  localparam int IDX_W      = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int UNIT_W     = ADDR_W - UNIT_SHIFT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [NUM_ROWS*BND_W-1:0] bounds_i,
  input  logic [1:0]                hole_en_i,
  output logic [NUM_ROWS-1:0]       row_sel_o,
  output logic [IDX_W-1:0]          row_idx_o,
  output logic                      dram_hit_o,
  output logic                      hole_o
);
  logic [NUM_ROWS-1:0] row_match_w;
  logic [NUM_ROWS-1:0] pick_w;
  logic [IDX_W-1:0]    pick_idx_w;
  logic                any_row_w;
  logic                hole_hit_w;
  logic                order_raw_w;
  logic                order_err_w;

  drb_row_cmp #(
    .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .UNIT_W(UNIT_W)
  ) u_cmp (
    .unit_i     (addr_i[ADDR_W-1:UNIT_SHIFT]),
    .bounds_i   (bounds_i),
    .match_o    (row_match_w),
    .order_err_o(order_raw_w)
  );

  drb_prio_pick #(.N(NUM_ROWS), .IDX_W(IDX_W)) u_pick (
    .match_i (row_match_w),
    .onehot_o(pick_w),
    .idx_o   (pick_idx_w),
    .any_o   (any_row_w)
  );

  drb_hole_chk #(.ADDR_W(ADDR_W)) u_hole (
    .addr_i   (addr_i),
    .hole_en_i(hole_en_i),
    .in_hole_o(hole_hit_w)
  );

  // Misordering report for the checker; zero when the check is disabled.
  assign order_err_w = ORDER_CHECK ? order_raw_w : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_sel_o  <= '0;
      row_idx_o  <= '0;
      dram_hit_o <= 1'b0;
      hole_o     <= 1'b0;
    end else begin
      row_sel_o  <= hole_hit_w ? '0 : pick_w;
      row_idx_o  <= hole_hit_w ? '0 : pick_idx_w;
      dram_hit_o <= any_row_w & ~hole_hit_w;
      hole_o     <= hole_hit_w;
    end
  end
endmodule

// File: rtl/drb_decoder_chk.sv
module drb_decoder_chk #(
  parameter int ADDR_W      = 32,
  parameter int NUM_ROWS    = 8,
  parameter int IDX_W       = 3,
  parameter bit ORDER_CHECK = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [1:0]          hole_en_i,
  input logic [NUM_ROWS-1:0] row_sel_o,
  input logic [IDX_W-1:0]    row_idx_o,
  input logic                dram_hit_o,
  input logic                hole_o,
  input logic                order_err_w
);
  logic [31:0] a32;
  assign a32 = 32'(addr_i);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel_o)); // R3
  AST_HIT_IFF_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    dram_hit_o == (row_sel_o != '0)); // R3
  AST_IDX_POINTS: assert property (@(posedge clk) disable iff (!rst_n)
    dram_hit_o |-> row_sel_o[row_idx_o]); // R3
  AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_hit_o |-> row_idx_o == '0); // R5
  AST_HOLE_LOW_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (hole_en_i == 2'b01 && a32 >= 32'h0008_0000 && a32 < 32'h000A_0000)
      |=> (hole_o && !dram_hit_o && row_sel_o == '0)); // R6
  AST_HOLE_HIGH_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (hole_en_i == 2'b10 && a32 >= 32'h00F0_0000 && a32 < 32'h0100_0000)
      |=> (hole_o && !dram_hit_o && row_sel_o == '0)); // R7
  AST_HOLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (hole_en_i == 2'b00 || hole_en_i == 2'b11) |=> !hole_o); // R8

  if (ORDER_CHECK) begin : g_order
    AST_BOUND_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      !order_err_w); // R9
  end
endmodule

bind drb_decoder drb_decoder_chk #(
  .ADDR_W(ADDR_W), .NUM_ROWS(NUM_ROWS), .IDX_W(IDX_W), .ORDER_CHECK(ORDER_CHECK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_i     (addr_i),
  .hole_en_i  (hole_en_i),
  .row_sel_o  (row_sel_o),
  .row_idx_o  (row_idx_o),
  .dram_hit_o (dram_hit_o),
  .hole_o     (hole_o),
  .order_err_w(order_err_w)
);

// File: tb/drb_decoder_tb_top.sv
module drb_decoder_tb_top;
  localparam longint unsigned UNIT = 64'd8388608; // 8 MB

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [63:0] bnd = '0;
  logic [63:0] bnd_nm = '0;
  logic [1:0]  hcode = 2'b00;

  logic [7:0] sel_a, sel_b;
  logic [2:0] idx_a, idx_b;
  logic       hit_a, hit_b, hole_a, hole_b;

  int n_vec = 0;
  int n_bad = 0;
  int row1_sel_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  drb_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .bounds_i(bnd), .hole_en_i(hcode),
    .row_sel_o(sel_a), .row_idx_o(idx_a), .dram_hit_o(hit_a), .hole_o(hole_a));

  drb_decoder #(.ORDER_CHECK(1'b0)) dut_nm (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .bounds_i(bnd_nm), .hole_en_i(hcode),
    .row_sel_o(sel_b), .row_idx_o(idx_b), .dram_hit_o(hit_b), .hole_o(hole_b));

  // Expected outputs from the requirements, by integer arithmetic.
  task automatic expect_of(input logic [31:0] a, input logic [63:0] b, input logic [1:0] hc,
                           output logic [7:0] s, output logic [2:0] ix,
                           output logic h, output logic ho);
    longint unsigned av, u, prev, cur;
    bit in_low, in_high;
    av = 64'(a);
    in_low  = (av >= 64'd524288)   && (av < 64'd655360);
    in_high = (av >= 64'd15728640) && (av < 64'd16777216);
    s = '0; ix = '0; h = 1'b0;
    ho = (hc == 2'b01 && in_low) || (hc == 2'b10 && in_high);
    if (!ho) begin
      u = av / UNIT;
      prev = 0;
      for (int r = 0; r < 8; r++) begin
        cur = 64'(b[r*8 +: 8]);
        if (!h && u >= prev && u < cur) begin
          h = 1'b1; s = 8'(1) << r; ix = 3'(r);
        end
        prev = cur;
      end
    end
  endtask

  function automatic string tag_of(input logic [31:0] a, input logic [1:0] hc, input logic h,
                                   input logic ho);
    if (ho) return (hc == 2'b01) ? "R6" : "R7";
    if ((a >= 32'h80000 && a < 32'hA0000) || (a >= 32'hF00000 && a < 32'h1000000))
      return "R8";
    if (h) return "R3";
    return "R5";
  endfunction

  task automatic compare(input string tg, input logic [7:0] s, input logic [2:0] ix,
                         input logic h, input logic ho, input logic [7:0] es,
                         input logic [2:0] eix, input logic eh, input logic eho);
    n_vec++;
    if (s !== es || ix !== eix || h !== eh || ho !== eho) begin
      n_bad++;
      $display("FAIL %s addr=%h code=%b: got sel=%b idx=%0d hit=%b hole=%b, expected sel=%b idx=%0d hit=%b hole=%b",
               tg, addr, hcode, s, ix, h, ho, es, eix, eh, eho);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [1:0] hc);
    logic [7:0] es; logic [2:0] eix; logic eh, eho;
    @(negedge clk);
    addr = a; hcode = hc;
    @(negedge clk);
    expect_of(a, bnd, hc, es, eix, eh, eho);
    compare(tag_of(a, hc, eh, eho), sel_a, idx_a, hit_a, hole_a, es, eix, eh, eho);
    if (sel_a[1]) row1_sel_cnt++;
  endtask

  task automatic sweep_cfg(input logic [63:0] b);
    longint unsigned top, a, step;
    bnd = b;
    top = 64'(b[63:56]) * UNIT + 64'd16777216;
    for (int hc = 0; hc < 4; hc++) begin
      a = 0;
      while (a < top) begin
        apply(32'(a), 2'(hc));
        step = (a < 64'd33554432) ? 64'd524288 : 64'd4194304;
        a = a + step;
      end
      for (int r = 0; r < 8; r++) begin
        longint unsigned e;
        e = 64'(b[r*8 +: 8]) * UNIT;
        if (e > 0) apply(32'(e - 1), 2'(hc));
        apply(32'(e), 2'(hc));
      end
      // window edges
      apply(32'h0007_FFFF, 2'(hc)); apply(32'h0008_0000, 2'(hc));
      apply(32'h0009_FFFF, 2'(hc)); apply(32'h000A_0000, 2'(hc));
      apply(32'h00EF_FFFF, 2'(hc)); apply(32'h00F0_0000, 2'(hc));
      apply(32'h00FF_FFFF, 2'(hc)); apply(32'h0100_0000, 2'(hc));
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] es; logic [2:0] eix; logic eh, eho;
    bnd = 64'h0807_0605_0403_0201;
    bnd_nm = bnd;
    addr = 32'h0000_1000;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero while reset is low
    compare("R1", sel_a, idx_a, hit_a, hole_a, 8'h00, 3'd0, 1'b0, 1'b0);
    rst_n = 1'b1;

    // R2: outputs change only at the clock edge after the inputs
    apply(32'h0180_0000, 2'b00);           // row 3
    @(negedge clk);
    addr = 32'h0000_0000;                  // row 0
    #2;
    compare("R2", sel_a, idx_a, hit_a, hole_a, 8'h08, 3'd3, 1'b1, 1'b0);
    @(negedge clk);
    compare("R2", sel_a, idx_a, hit_a, hole_a, 8'h01, 3'd0, 1'b1, 1'b0);

    // R3/R5/R6/R7/R8 sweeps over boundary sets
    sweep_cfg(64'h0807_0605_0403_0201);    // 8 MB per row
    sweep_cfg(64'h0000_0000_0000_0000);    // no memory at all
    sweep_cfg(64'h0808_0808_0808_0808);    // one 64 MB row
    sweep_cfg(64'h0303_0303_0300_0000);    // empty leading rows
    sweep_cfg(64'hFFC8_7864_4129_2810);    // reaches top code 255

    // R4: row 1 has the same end value as row 0 and must never be chosen
    row1_sel_cnt = 0;
    sweep_cfg(64'h0A08_0804_0404_0202);
    n_vec++;
    if (row1_sel_cnt != 0) begin
      n_bad++;
      $display("FAIL R4: got %0d selections of empty row 1, expected 0", row1_sel_cnt);
    end

    // R9: misordered end values on the instance without the order check
    bnd = 64'h0807_0605_0403_0201;
    bnd_nm = 64'h0306_0A02_0804_0205;
    for (int k = 0; k < 96; k++) begin
      @(negedge clk);
      addr = 32'(k) * 32'h0010_0000 + 32'h40;
      hcode = 2'b00;
      @(negedge clk);
      expect_of(addr, bnd_nm, 2'b00, es, eix, eh, eho);
      compare("R9", sel_b, idx_b, hit_b, hole_b, es, eix, eh, eho);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule